// File: doc/BRIEF.md
# Four-Bit Carry Lookahead Adder Slice

This block adds two 4-bit operands and a carry-in in a single combinational pass. Each bit position forms a generate term (both operand bits set) and a propagate term (exactly one operand bit set). Every internal carry and the carry-out is then a flat sum of products of those terms and the carry-in. No carry is derived from the carry of the bit below, so no chain runs across the slice.

The slice also drives a group generate and a group propagate output. A second-level lookahead unit uses them to combine several slices into a wider adder without rippling between slices. The block has no storage, no clock and no reset.

Top module: `cla4_slice`

## Requirements
- R1: `sum_o` equals the low four bits of `a_i + b_i + carry_in` for every input combination.
- R2: `carry_out` equals bit 4 (the fifth bit) of `a_i + b_i + carry_in` for every input combination.
- R3: `grp_prop` is 1 exactly when `a_i XOR b_i` is `4'b1111`, i.e. every bit position propagates.
- R4: `grp_gen` is 1 exactly when `a_i + b_i` (carry-in zero) is 16 or more, i.e. the slice produces a carry by itself.
- R5: `carry_out` equals `grp_gen OR (grp_prop AND carry_in)` at all times.
- R6: `grp_gen` and `grp_prop` do not depend on `carry_in`; toggling `carry_in` with fixed operands leaves both unchanged.
- R7: When every position propagates, `carry_in` passes to all positions: `sum_o` is `4'b0000` and `carry_out` is 1 for `carry_in` = 1, and `sum_o` is `4'b1111` and `carry_out` is 0 for `carry_in` = 0.
- R8: `grp_gen` and `grp_prop` are never 1 at the same time.
- R9: With both operands and the carry-in zero, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 4 | Sum bits |
| carry_out | output | 1 | Carry out of bit 3 |
| grp_gen | output | 1 | Slice generates a carry regardless of carry-in |
| grp_prop | output | 1 | Slice passes carry-in through to its carry-out |

## Verification
Assertions placed next to the logic check the arithmetic result (R1, R2), the carry-out decomposition into group terms (R5), full-propagate detection (R3) and the exclusivity of the group pair (R8) on every input change. Independence of the group outputs from the carry-in (R6) relates two separate input states, so only the bench's paired stimuli show it. The bench also walks all 512 input combinations against its own arithmetic reference, which covers the carry-through corner (R7) and the all-zero case (R9).

// File: rtl/cla4_pkg.sv
package cla4_pkg;

    localparam int unsigned SLICE_W = 4;

    typedef logic [SLICE_W-1:0] slice_vec_t;

    // per-bit lookahead terms
    typedef struct packed {
        slice_vec_t gen;
        slice_vec_t prop;
    } bit_terms_t;

    // slice-level pair handed upward
    typedef struct packed {
        logic gen;
        logic prop;
    } group_terms_t;

    // Carry into position j (1..SLICE_W), built as an independent flat
    // sum of products: OR over k<j of gen[k] AND prop[k+1..j-1], plus
    // c0 AND prop[0..j-1]. No lower carry is reused.
    function automatic logic flat_carry(input slice_vec_t g,
                                        input slice_vec_t p,
                                        input logic       c0,
                                        input int         j);
        logic acc;
        logic term;
        acc = 1'b0;
        for (int k = 0; k < j; k++) begin
            term = g[k];
            for (int m = k + 1; m < j; m++) begin
                term = term & p[m];
            end
            acc = acc | term;
        end
        term = c0;
        for (int m = 0; m < j; m++) begin
            term = term & p[m];
        end
        acc = acc | term;
        return acc;
    endfunction

endpackage

// File: rtl/cla4_bit_terms.sv
module cla4_bit_terms
    import cla4_pkg::*;
(
    input  slice_vec_t op_a,
    input  slice_vec_t op_b,
    output bit_terms_t terms
);

    for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        assign terms.gen[i]  = op_a[i] & op_b[i];
        assign terms.prop[i] = op_a[i] ^ op_b[i];
    end

endmodule

// File: rtl/cla4_lookahead.sv
module cla4_lookahead
    import cla4_pkg::*;
(
    input  bit_terms_t       terms,
    input  logic             c0,
    output logic [SLICE_W:0] carries,
    output group_terms_t     group
);

    assign carries[0] = c0;

    for (genvar j = 1; j <= SLICE_W; j++) begin : g_carry
        assign carries[j] = flat_carry(terms.gen, terms.prop, c0, j);
    end

    // group generate is the top carry with the carry-in forced low
    assign group.gen  = flat_carry(terms.gen, terms.prop, 1'b0, SLICE_W);
    assign group.prop = &terms.prop;

    always_comb begin
        // R8: a propagating position never also generates
        p_grp_excl_r8: assert (!(group.gen && group.prop))
            else $error("group generate and propagate both high");
        // R5: top carry decomposes into the group pair
        p_cout_split_r5: assert (carries[SLICE_W] == (group.gen | (group.prop & c0)))
            else $error("carry-out disagrees with group terms");
    end

endmodule

// File: rtl/cla4_sum_bits.sv
module cla4_sum_bits
    import cla4_pkg::*;
(
    input  slice_vec_t       prop,
    input  logic [SLICE_W:0] carries,
    output slice_vec_t       sum
);

    for (genvar i = 0; i < SLICE_W; i++) begin : g_sum
        assign sum[i] = prop[i] ^ carries[i];
    end

endmodule

// File: rtl/cla4_slice.sv
module cla4_slice
    import cla4_pkg::*;
(
    input  logic [3:0] a_i,
    input  logic [3:0] b_i,
    input  logic       carry_in,
    output logic [3:0] sum_o,
    output logic       carry_out,
    output logic       grp_gen,
    output logic       grp_prop
);

    bit_terms_t       terms;
    logic [SLICE_W:0] carries;
    group_terms_t     group;

    cla4_bit_terms u_terms (
        .op_a  (a_i),
        .op_b  (b_i),
        .terms (terms)
    );

    cla4_lookahead u_look (
        .terms   (terms),
        .c0      (carry_in),
        .carries (carries),
        .group   (group)
    );

    cla4_sum_bits u_sum (
        .prop    (terms.prop),
        .carries (carries),
        .sum     (sum_o)
    );

    assign carry_out = carries[SLICE_W];
    assign grp_gen   = group.gen;
    assign grp_prop  = group.prop;

    logic [SLICE_W:0] ref_total;
    always_comb begin
        ref_total = {1'b0, a_i} + {1'b0, b_i} + {{SLICE_W{1'b0}}, carry_in};
        // R1 and R2: outputs match arithmetic addition
        p_sum_r1: assert (sum_o == ref_total[SLICE_W-1:0])
            else $error("sum bits wrong");
        p_cout_r2: assert (carry_out == ref_total[SLICE_W])
            else $error("carry-out wrong");
        // R3: full propagate detected
        p_prop_r3: assert (grp_prop == ((a_i ^ b_i) == 4'b1111))
            else $error("group propagate wrong");
    end

endmodule

// File: tb/cla4_slice_bench.sv
module cla4_slice_bench;

    logic       clk = 1'b0;
    logic [3:0] a_i, b_i;
    logic       carry_in;
    logic [3:0] sum_o;
    logic       carry_out, grp_gen, grp_prop;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    cla4_slice u_cla4_slice (
        .a_i       (a_i),
        .b_i       (b_i),
        .carry_in  (carry_in),
        .sum_o     (sum_o),
        .carry_out (carry_out),
        .grp_gen   (grp_gen),
        .grp_prop  (grp_prop)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d cin=%0d)",
                     req, act, exp, a_i, b_i, carry_in);
        end
    endtask

    task automatic apply(input int a, input int b, input int c);
        @(negedge clk);
        a_i      = a[3:0];
        b_i      = b[3:0];
        carry_in = c[0];
        @(posedge clk);
        #1;
    endtask

    // R9: all-zero inputs
    task automatic t_zero();
        apply(0, 0, 0);
        check("R9 sum", int'(sum_o), 0);
        check("R9 cout", int'(carry_out), 0);
        check("R9 ggen", int'(grp_gen), 0);
        check("R9 gprop", int'(grp_prop), 0);
    endtask

    // R1 R2 R3 R4 R5 R8 over every combination
    task automatic t_exhaustive();
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 2; c++) begin
                    int tot;
                    int ex_p;
                    apply(a, b, c);
                    tot  = a + b + c;
                    ex_p = ((a ^ b) == 15) ? 1 : 0;
                    check("R1 sum", int'(sum_o), tot % 16);
                    check("R2 cout", int'(carry_out), tot / 16);
                    check("R3 gprop", int'(grp_prop), ex_p);
                    check("R4 ggen", int'(grp_gen), (a + b >= 16) ? 1 : 0);
                    check("R5 split", int'(carry_out),
                          int'(grp_gen) | (int'(grp_prop) & c));
                    check("R8 excl", int'(grp_gen & grp_prop), 0);
                end
            end
        end
    endtask

    // R6: group pair identical for both carry-in values
    task automatic t_cin_indep();
        int pairs [4][2] = '{'{9, 6}, '{15, 1}, '{7, 7}, '{3, 4}};
        for (int i = 0; i < 4; i++) begin
            int g0, p0;
            apply(pairs[i][0], pairs[i][1], 0);
            g0 = int'(grp_gen);
            p0 = int'(grp_prop);
            apply(pairs[i][0], pairs[i][1], 1);
            check("R6 ggen", int'(grp_gen), g0);
            check("R6 gprop", int'(grp_prop), p0);
        end
    endtask

    // R7: carry passes through a fully propagating slice
    task automatic t_pass_through();
        apply(10, 5, 1);
        check("R7 sum c1", int'(sum_o), 0);
        check("R7 cout c1", int'(carry_out), 1);
        apply(12, 3, 0);
        check("R7 sum c0", int'(sum_o), 15);
        check("R7 cout c0", int'(carry_out), 0);
        check("R7 gprop", int'(grp_prop), 1);
    endtask

    initial begin
        a_i = '0; b_i = '0; carry_in = 1'b0;
        t_zero();
        t_exhaustive();
        t_cin_indep();
        t_pass_through();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule